// File: doc/BRIEF.md
# Prefix-Controlled 16-bit ALU

This block is the arithmetic and logic stage of a small graphics coprocessor. Each cycle it may accept one operation, given as an opcode, a source register value, a second register value, a 4-bit immediate from the opcode, and two mode bits (alt1, alt2). Earlier prefix instructions set those mode bits. They choose between the register and the immediate operand, and they turn one base operation into its variant: add into add-with-carry, subtract into subtract-with-borrow or compare, AND into bit-clear, OR into XOR, and arithmetic shift into its rounding form.

The result, a destination write-enable, a flag-update strobe and a prefix-clear pulse are registered. They appear in the cycle after the operation is accepted and last for one cycle. The block holds the four condition flags (carry, overflow, sign, zero). An operation changes only the flags it defines, and the carry it holds feeds the carry-using operations.

Top module: `prefix_alu`

## Requirements
- R1: While rst_n is low, and in the first cycle after it goes high, result, dst_we, flag_upd, prefix_clr and all four flags are 0.
- R2: An op_valid cycle with an op_code from 0 to 12 gives flag_upd=1 and prefix_clr=1 for exactly the next cycle. Without op_valid, or with op_code 13 to 15, the next cycle shows flag_upd=0, prefix_clr=0 and dst_we=0, and no flag changes.
- R3: Opcodes are ADD=0, SUB=1, AND=2, OR=3, NOT=4, LSR=5, ASR=6, ROL=7, ROR=8, SWAP=9, SEXT=10, LOB=11, HIB=12. With alt2=1, ADD, AND and OR use the zero-extended imm_val in place of reg_val. SUB uses imm_val only when alt2=1 and alt1=0.
- R4: ADD computes the 17-bit sum src+operand, plus the held carry when alt1=1. Carry is sum bit 16. Overflow is set when both operands share bit 15 and the result's bit 15 differs from it.
- R5: SUB computes src-operand. With alt1=1 and alt2=0 it also subtracts 1 when the held carry is 0. Carry is 1 when the true difference is at least 0. Overflow is set when the operands differ in bit 15 and the result differs from src in bit 15.
- R6: AND gives src&operand, or src&~operand when alt1=1. OR gives src|operand, or src^operand when alt1=1. NOT gives ~src. These three update only sign and zero.
- R7: LSR shifts in a 0 at the top and ASR copies bit 15. Both move the old bit 0 into carry. With alt1=1, ASR of 0xFFFF gives 0x0000. Shifts and rotates leave overflow unchanged.
- R8: ROL moves the held carry into bit 0 and the old bit 15 into carry. ROR moves the held carry into bit 15 and the old bit 0 into carry.
- R9: SWAP exchanges the two bytes, and SEXT copies bit 7 into bits 15..8. Both update only sign and zero.
- R10: LOB and HIB return the low or high byte of src in bits 7..0, with bits 15..8 zero, and take sign from bit 7. Every other operation takes sign from bit 15.
- R11: On every flag update, the zero flag is 1 exactly when the 16-bit result is 0.
- R12: dst_we is 1 for every accepted operation except SUB with alt1=1 and alt2=1, which is a compare. The compare updates all four flags but does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector |
| alt1 | input | 1 | First prefix mode bit |
| alt2 | input | 1 | Second prefix mode bit |
| src_val | input | 16 | Source register value |
| reg_val | input | 16 | Second operand register value |
| imm_val | input | 4 | Immediate field of the opcode |
| result | output | 16 | Operation result |
| dst_we | output | 1 | Destination register write-enable |
| flag_upd | output | 1 | Flag-update strobe |
| prefix_clr | output | 1 | Request to clear alt1/alt2 |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions check, on every cycle, the following:
- the one-cycle strobe and prefix-clear timing;
- that flags stay put on idle or undefined cycles;
- the missing write on a compare;
- that logic, byte and shift operations preserve carry and overflow as their class requires;
- the zero-extended byte-extract result with its bit-7 sign;
- that the zero flag agrees with the result.

The arithmetic values can only be shown by the bench scenarios. These are carry and overflow from add and subtract, borrow chaining from a prior carry, immediate versus register selection under each prefix combination, the rotate carry paths and the 0xFFFF rounding case. The bench checks each of them against its own model of the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 16;
    localparam int IMM_W  = 4;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOT  = 4'd4,
        OP_LSR  = 4'd5,
        OP_ASR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_SWAP = 4'd9,
        OP_SEXT = 4'd10,
        OP_LOB  = 4'd11,
        OP_HIB  = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic v;
        logic s;
        logic z;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              we;
        logic              upd;
        logic              pclr;
        alu_flags_t        flags;
    } alu_state_t;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  alu_op_e         op,
    input  logic            alt1,
    input  logic            alt2,
    input  logic [W-1:0]    reg_val,
    input  logic [IW-1:0]   imm_val,
    output logic [W-1:0]    operand
);
    localparam int PAD_W = W - IW;

    logic use_imm;

    always_comb begin
        if (op == OP_SUB) begin
            use_imm = alt2 && !alt1;
        end else begin
            use_imm = alt2;
        end
        operand = use_imm ? {{PAD_W{1'b0}}, imm_val} : reg_val;
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic         is_sub,
    input  logic         alt1,
    input  logic         alt2,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         c,
    output logic         v
);
    logic [W:0] wide;
    logic       extra;

    always_comb begin
        if (!is_sub) begin
            extra = alt1 & cin;
            wide  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, extra};
            c     = wide[W];
            v     = ~(a[W-1] ^ b[W-1]) & (b[W-1] ^ wide[W-1]);
        end else begin
            extra = alt1 & ~alt2 & ~cin;
            wide  = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, extra};
            c     = ~wide[W];
            v     = (a[W-1] ^ b[W-1]) & (a[W-1] ^ wide[W-1]);
        end
        res = wide[W-1:0];
    end
endmodule

// File: rtl/alu_unary.sv
module alu_unary
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic         alt1,
    input  logic         cin,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         c,
    output logic         sign_lo
);
    localparam int H = W / 2;

    always_comb begin
        res     = '0;
        c       = cin;
        sign_lo = 1'b0;
        case (op)
            OP_AND:  res = alt1 ? (a & ~b) : (a & b);
            OP_OR:   res = alt1 ? (a ^ b) : (a | b);
            OP_NOT:  res = ~a;
            OP_LSR: begin
                res = {1'b0, a[W-1:1]};
                c   = a[0];
            end
            OP_ASR: begin
                res = {a[W-1], a[W-1:1]} + {{(W-1){1'b0}}, (alt1 & (&a))};
                c   = a[0];
            end
            OP_ROL: begin
                res = {a[W-2:0], cin};
                c   = a[W-1];
            end
            OP_ROR: begin
                res = {cin, a[W-1:1]};
                c   = a[0];
            end
            OP_SWAP: res = {a[H-1:0], a[W-1:H]};
            OP_SEXT: res = {{H{a[H-1]}}, a[H-1:0]};
            OP_LOB: begin
                res     = {{H{1'b0}}, a[H-1:0]};
                sign_lo = 1'b1;
            end
            OP_HIB: begin
                res     = {{H{1'b0}}, a[W-1:H]};
                sign_lo = 1'b1;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/prefix_alu.sv
module prefix_alu
    import alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic          alt1,
    input  logic          alt2,
    input  logic [W-1:0]  src_val,
    input  logic [W-1:0]  reg_val,
    input  logic [IW-1:0] imm_val,
    output logic [W-1:0]  result,
    output logic          dst_we,
    output logic          flag_upd,
    output logic          prefix_clr,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_s,
    output logic          flag_z
);
    localparam int H = W / 2;

    alu_state_t st_d, st_q;
    alu_op_e    op;
    logic       op_known;
    logic [W-1:0] operand;
    logic [W-1:0] ar_res, un_res, sel_res;
    logic         ar_c, ar_v, un_c, un_slo;
    logic [3:0]   mask;
    alu_flags_t   calc;

    assign op       = alu_op_e'(op_code);
    assign op_known = (op_code <= 4'(OP_HIB));

    alu_operand_sel #(.W(W), .IW(IW)) i_opsel (
        .op(op), .alt1(alt1), .alt2(alt2),
        .reg_val(reg_val), .imm_val(imm_val), .operand(operand)
    );

    alu_arith #(.W(W)) i_arith (
        .is_sub(op == OP_SUB), .alt1(alt1), .alt2(alt2), .cin(st_q.flags.c),
        .a(src_val), .b(operand), .res(ar_res), .c(ar_c), .v(ar_v)
    );

    alu_unary #(.W(W)) i_unary (
        .op(op), .alt1(alt1), .cin(st_q.flags.c),
        .a(src_val), .b(operand), .res(un_res), .c(un_c), .sign_lo(un_slo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.upd  = 1'b0;
        st_d.pclr = 1'b0;

        case (op)
            OP_ADD, OP_SUB:                 mask = 4'b1111;
            OP_LSR, OP_ASR, OP_ROL, OP_ROR: mask = 4'b1011;
            default:                        mask = 4'b0011;
        endcase

        if (op == OP_ADD || op == OP_SUB) begin
            sel_res = ar_res;
            calc.c  = ar_c;
            calc.v  = ar_v;
        end else begin
            sel_res = un_res;
            calc.c  = un_c;
            calc.v  = st_q.flags.v;
        end
        calc.s = un_slo ? sel_res[H-1] : sel_res[W-1];
        calc.z = (sel_res == '0);

        if (op_valid && op_known) begin
            st_d.result  = sel_res;
            st_d.we      = !(op == OP_SUB && alt1 && alt2);
            st_d.upd     = 1'b1;
            st_d.pclr    = 1'b1;
            st_d.flags.c = mask[3] ? calc.c : st_q.flags.c;
            st_d.flags.v = mask[2] ? calc.v : st_q.flags.v;
            st_d.flags.s = mask[1] ? calc.s : st_q.flags.s;
            st_d.flags.z = mask[0] ? calc.z : st_q.flags.z;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result     = st_q.result;
    assign dst_we     = st_q.we;
    assign flag_upd   = st_q.upd;
    assign prefix_clr = st_q.pclr;
    assign flag_c     = st_q.flags.c;
    assign flag_v     = st_q.flags.v;
    assign flag_s     = st_q.flags.s;
    assign flag_z     = st_q.flags.z;
endmodule

// File: rtl/prefix_alu_chk.sv
module prefix_alu_chk #(
    parameter int W  = alu_pkg::DATA_W,
    parameter int IW = alu_pkg::IMM_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic          alt1,
    input logic          alt2,
    input logic [W-1:0]  result,
    input logic          dst_we,
    input logic          flag_upd,
    input logic          prefix_clr,
    input logic          flag_c,
    input logic          flag_v,
    input logic          flag_s,
    input logic          flag_z
);
    localparam int H = W / 2;

    logic accept;
    assign accept = op_valid && (op_code <= 4'd12);

    assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (flag_upd && prefix_clr));

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!flag_upd && !prefix_clr && !dst_we));

    assert_hold_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable({flag_c, flag_v, flag_s, flag_z}));

    assert_cmp_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == 4'd1 && alt1 && alt2) |=> !dst_we);

    assert_logic_keep_cv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd2 || op_code == 4'd3 || op_code == 4'd4 ||
                      op_code == 4'd9 || op_code == 4'd10 || op_code == 4'd11 ||
                      op_code == 4'd12)) |=> $stable({flag_c, flag_v}));

    assert_shift_keep_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd5 && op_code <= 4'd8) |=> $stable(flag_v));

    assert_byte_extract_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd11 || op_code == 4'd12)) |=>
            (result[W-1:H] == '0 && flag_s == result[H-1]));

    assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd |-> (flag_z == (result == '0)));
endmodule

bind prefix_alu prefix_alu_chk #(.W(W), .IW(IW)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .alt1(alt1), .alt2(alt2), .result(result), .dst_we(dst_we),
    .flag_upd(flag_upd), .prefix_clr(prefix_clr), .flag_c(flag_c),
    .flag_v(flag_v), .flag_s(flag_s), .flag_z(flag_z)
);

// File: tb/test_prefix_alu.sv
module test_prefix_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        alt1 = 1'b0, alt2 = 1'b0;
    logic [15:0] src_val = '0, reg_val = '0;
    logic [3:0]  imm_val = '0;
    logic [15:0] result;
    logic        dst_we, flag_upd, prefix_clr, flag_c, flag_v, flag_s, flag_z;

    int total = 0;
    int bad = 0;
    logic mc = 0, mv = 0, ms = 0, mz = 0;

    always #10 clk = ~clk;

    prefix_alu i_prefix_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .alt1(alt1), .alt2(alt2), .src_val(src_val), .reg_val(reg_val),
        .imm_val(imm_val), .result(result), .dst_we(dst_we),
        .flag_upd(flag_upd), .prefix_clr(prefix_clr), .flag_c(flag_c),
        .flag_v(flag_v), .flag_s(flag_s), .flag_z(flag_z)
    );

    // op, alt1, alt2, src, reg, imm
    localparam int NV = 22;
    localparam logic [41:0] VECS [0:NV-1] = '{
        {4'd0,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 4'h0},
        {4'd0,  1'b0, 1'b1, 16'hFFFF, 16'h1234, 4'h1},
        {4'd0,  1'b1, 1'b0, 16'h0001, 16'h0001, 4'h0},
        {4'd1,  1'b0, 1'b0, 16'h0005, 16'h0005, 4'h0},
        {4'd1,  1'b0, 1'b1, 16'h0003, 16'h0100, 4'h5},
        {4'd1,  1'b1, 1'b0, 16'h0010, 16'h0001, 4'h0},
        {4'd1,  1'b1, 1'b1, 16'h8000, 16'h0001, 4'h7},
        {4'd2,  1'b0, 1'b0, 16'hF0F0, 16'h3C3C, 4'h0},
        {4'd2,  1'b1, 1'b0, 16'hF0F0, 16'h3C3C, 4'h0},
        {4'd3,  1'b0, 1'b1, 16'h8000, 16'hFFFF, 4'hA},
        {4'd3,  1'b1, 1'b0, 16'hAAAA, 16'hAAAA, 4'h0},
        {4'd4,  1'b0, 1'b0, 16'h0000, 16'h0000, 4'h0},
        {4'd5,  1'b0, 1'b0, 16'h0003, 16'h0000, 4'h0},
        {4'd6,  1'b0, 1'b0, 16'h8001, 16'h0000, 4'h0},
        {4'd6,  1'b1, 1'b0, 16'hFFFE, 16'h0000, 4'h0},
        {4'd7,  1'b0, 1'b0, 16'h8000, 16'h0000, 4'h0},
        {4'd7,  1'b0, 1'b0, 16'h4001, 16'h0000, 4'h0},
        {4'd8,  1'b0, 1'b0, 16'h0001, 16'h0000, 4'h0},
        {4'd9,  1'b0, 1'b0, 16'h12AB, 16'h0000, 4'h0},
        {4'd10, 1'b0, 1'b0, 16'h5580, 16'h0000, 4'h0},
        {4'd11, 1'b0, 1'b0, 16'h12F0, 16'h0000, 4'h0},
        {4'd12, 1'b0, 1'b0, 16'h8034, 16'h0000, 4'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements; updates model flags.
    task automatic model(input int op, input bit a1, input bit a2, input int src,
                         input int rv, input int imm, output int r, output bit we);
        int b, t;
        bit lo;
        lo = 0;
        we = 1;
        case (op)
            0: begin
                b = a2 ? imm : rv;
                t = src + b + ((a1 && mc) ? 1 : 0);
                r = t & 16'hFFFF;
                mc = (t >> 16) & 1;
                mv = (src[15] == b[15]) && (r[15] != src[15]);
            end
            1: begin
                b = (a2 && !a1) ? imm : rv;
                t = src - b - ((a1 && !a2 && !mc) ? 1 : 0);
                r = t & 16'hFFFF;
                mc = (t >= 0);
                mv = (src[15] != b[15]) && (r[15] != src[15]);
                we = !(a1 && a2);
            end
            2: begin b = a2 ? imm : rv; r = a1 ? (src & ~b) : (src & b); r &= 16'hFFFF; end
            3: begin b = a2 ? imm : rv; r = a1 ? (src ^ b) : (src | b); end
            4: r = ~src & 16'hFFFF;
            5: begin r = src >> 1; mc = src[0]; end
            6: begin
                r = (src >> 1) | (src & 16'h8000);
                if (a1 && src == 16'hFFFF) r = 0;
                mc = src[0];
            end
            7: begin r = ((src << 1) & 16'hFFFF) | int'(mc); mc = src[15]; end
            8: begin r = (src >> 1) | (int'(mc) << 15); mc = src[0]; end
            9: r = ((src & 16'hFF) << 8) | (src >> 8);
            10: r = (src & 16'h80) ? (src | 16'hFF00) : (src & 16'h00FF);
            11: begin r = src & 16'hFF; lo = 1; end
            default: begin r = src >> 8; lo = 1; end
        endcase
        ms = lo ? r[7] : r[15];
        mz = (r == 0);
    endtask

    task automatic drive(input int op, input bit a1, input bit a2, input int src,
                         input int rv, input int imm);
        op_valid = 1'b1;
        op_code  = 4'(op);
        alt1     = a1;
        alt2     = a2;
        src_val  = 16'(src);
        reg_val  = 16'(rv);
        imm_val  = 4'(imm);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int er;
        bit ewe;
        logic [3:0] fl;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {result, dst_we, flag_upd, prefix_clr, flag_c, flag_v, flag_s, flag_z}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {result, dst_we, flag_upd, prefix_clr, flag_c, flag_v, flag_s, flag_z}, '0);

        // Vector walk (R3..R10 per op)
        for (int i = 0; i < NV; i++) begin
            logic [41:0] vv;
            vv = VECS[i];
            model(int'(vv[41:38]), vv[37], vv[36], int'(vv[35:20]), int'(vv[19:4]), int'(vv[3:0]), er, ewe);
            drive(int'(vv[41:38]), vv[37], vv[36], int'(vv[35:20]), int'(vv[19:4]), int'(vv[3:0]));
            chk($sformatf("R3-vec%0d result (R4 R5 R6 R7 R8 R9 R10)", i), 32'(result), 32'(er));
            chk($sformatf("R12 vec%0d write-enable", i), 32'(dst_we), 32'(ewe));
            chk($sformatf("R11 vec%0d flags cvsz", i), {flag_c, flag_v, flag_s, flag_z}, {mc, mv, ms, mz});
            chk($sformatf("R2 vec%0d strobes", i), {flag_upd, prefix_clr}, 2'b11);
        end

        // R2: strobe lasts one cycle
        @(negedge clk);
        chk("R2 strobe drops", {flag_upd, prefix_clr, dst_we}, 3'b000);

        // R7: rounding shift of 0xFFFF
        drive(6, 1, 0, 16'hFFFF, 0, 0);
        chk("R7 rounding result", 32'(result), 32'h0);
        chk("R7 rounding flags c,z", {flag_c, flag_z, flag_s}, 3'b110);
        mc = 1; ms = 0; mz = 1;

        // R7: plain ASR of 0xFFFF stays 0xFFFF
        drive(6, 0, 0, 16'hFFFF, 0, 0);
        chk("R7 plain asr", 32'(result), 32'hFFFF);
        mc = 1; ms = 1; mz = 0;

        // R5 R12: compare 3 vs 5, no write, borrow
        drive(1, 1, 1, 16'h0003, 16'h0005, 4'h5);
        chk("R12 compare no write", 32'(dst_we), 32'h0);
        chk("R5 compare flags c,v,s,z", {flag_c, flag_v, flag_s, flag_z}, 4'b0010);
        mc = 0; mv = 0; ms = 1; mz = 0;

        // R5: borrow with carry clear subtracts one more
        drive(1, 1, 0, 16'h0000, 16'h0000, 0);
        chk("R5 sbc borrow", 32'(result), 32'hFFFF);
        chk("R5 sbc carry", 32'(flag_c), 32'h0);

        // R2: undefined opcode leaves everything
        fl = {flag_c, flag_v, flag_s, flag_z};
        drive(13, 0, 0, 16'h0000, 16'h0000, 0);
        chk("R2 undefined op strobes", {flag_upd, prefix_clr, dst_we}, 3'b000);
        chk("R2 undefined op flags", {flag_c, flag_v, flag_s, flag_z}, fl);

        // R2: idle cycle, inputs changing, flags untouched
        src_val = 16'h0000;
        op_code = 4'd4;
        @(negedge clk);
        chk("R2 idle flags", {flag_c, flag_v, flag_s, flag_z, flag_upd}, {fl, 1'b0});

        // R10: low byte with bit 7 set
        drive(11, 0, 0, 16'hFF80, 0, 0);
        chk("R10 lob result", 32'(result), 32'h0080);
        chk("R10 lob sign", 32'(flag_s), 32'h1);

        // R3: SUB with alt2 and alt1 both set uses register, not immediate
        drive(1, 1, 1, 16'h0009, 16'h0009, 4'h1);
        chk("R3 cmp uses register", 32'(flag_z), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule